// File: doc/BRIEF.md
# Indirect Pointer Unit with Auto-Modify

This block keeps a small set of 12-bit address pointers, each used to reach data memory indirectly. Software sets a pointer in one of two ways. It can write a whole 12-bit literal in one cycle, or it can write the pointer a byte at a time: an 8-bit low part and a 4-bit high part taken from the low nibble of the data byte. The same two parts can be read back as bytes, and the upper nibble of the high byte always reads as zero.

When the datapath accesses a pointer's virtual register, it raises the access strobe with a pointer select and a mode code. In the same cycle the block drives the effective data address, and at the next clock edge it applies any change the mode asks for. The modes are plain use, use-then-increment, use-then-decrement, increment-then-use, and an offset by the 8-bit working register value. The offset mode leaves both the pointer and the working register untouched.

All pointer arithmetic wraps modulo 4096, and nothing reports the wrap. The memory itself and the status flags belong to the neighbouring logic.

Top module: `indirect_ptr_unit`

## Requirements
- R1: After reset every pointer reads back as 0x000 and `effValid` is low.
- R2: A cycle with `loadEn` high writes the 12-bit `loadVal` into the pointer chosen by `loadSel`, effective at the next clock edge.
- R3: A byte write with `byteHi`=0 replaces pointer bits 7:0 with `byteData`. With `byteHi`=1 it replaces bits 11:8 with `byteData[3:0]`. Readback gives bits 7:0 when `rdHi`=0, and `{4'b0000, bits 11:8}` when `rdHi`=1.
- R4: Mode code 0 (plain) drives `effAddr` equal to the selected pointer and leaves the pointer unchanged.
- R5: Mode code 1 (post-increment) drives `effAddr` equal to the current pointer, and the pointer becomes pointer+1 after the edge.
- R6: Mode code 2 (post-decrement) drives `effAddr` equal to the current pointer, and the pointer becomes pointer-1 after the edge.
- R7: Mode code 3 (pre-increment) drives `effAddr` equal to pointer+1, and the pointer becomes that same value after the edge.
- R8: Mode code 4 (offset) drives `effAddr` equal to (pointer + unsigned `wreg`) mod 4096 and leaves the pointer unchanged.
- R9: Increments and decrements wrap over all 12 bits: 0xFFF+1 gives 0x000 and 0x000-1 gives 0xFFF.
- R10: An access changes only the pointer it selects. Mode codes 5 to 7 behave as plain. A select of 3 or above gives `effValid` low and changes no pointer. `effValid` is high whenever the strobe is high with a select of 0 to 2.
- R11: When several writes target the same pointer in one cycle, a literal load takes precedence over a byte write, and a byte write takes precedence over an auto-modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accEn | input | 1 | Access strobe for an indirect register |
| accSel | input | 2 | Pointer used by the access |
| accMode | input | 3 | Address-modification mode code |
| wreg | input | 8 | Working register value (offset mode) |
| loadEn | input | 1 | Load a 12-bit literal |
| loadSel | input | 2 | Pointer written by the load |
| loadVal | input | 12 | Literal value |
| byteWrEn | input | 1 | Byte write strobe |
| byteSel | input | 2 | Pointer written by the byte write |
| byteHi | input | 1 | 0 = low byte, 1 = high nibble |
| byteData | input | 8 | Byte write data |
| rdSel | input | 2 | Pointer read back |
| rdHi | input | 1 | 0 = low byte, 1 = high byte |
| rdData | output | 8 | Readback byte |
| effAddr | output | 12 | Effective data address of the access |
| effValid | output | 1 | Access targets an existing pointer |

## Verification
Some properties are checked on every cycle. After each accepted access, the selected pointer's next value must match its mode: stepped up, stepped down, or held. Pointers that receive no write must stay stable. The upper nibble of a high-byte readback must be zero, and at most one write source may act on a pointer at a time. The scenarios alone show the address arithmetic: the wrap at 0x000 and 0xFFF, offset sums that cross 4096 across a full sweep of the working register, the priority among load, byte write and auto-modify, and the fact that an invalid select or a reserved mode code leaves every pointer intact.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  typedef enum logic [2:0] {
    MODE_PLAIN   = 3'd0,
    MODE_POSTINC = 3'd1,
    MODE_POSTDEC = 3'd2,
    MODE_PREINC  = 3'd3,
    MODE_OFFSET  = 3'd4
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hit;      // access targets a real pointer
    logic addrInc;  // address is pointer + 1
    logic addrOff;  // address is pointer + wreg
    logic modify;   // pointer is rewritten by the access
    logic stepDown; // rewrite is pointer - 1 (else + 1)
  } ptrCtl_t;

endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import ptr_pkg::*;
#(
  parameter int NUM_PTR = 3,
  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accEn,
  input  logic [SEL_W-1:0]   accSel,
  input  logic [2:0]         accMode,
  input  logic               loadEn,
  input  logic [SEL_W-1:0]   loadSel,
  input  logic               byteWrEn,
  input  logic [SEL_W-1:0]   byteSel,
  output ptrCtl_t            ctl,
  output logic [NUM_PTR-1:0] ldHot,
  output logic [NUM_PTR-1:0] byteHot,
  output logic [NUM_PTR-1:0] modHot
);

  logic accHit;
  logic [NUM_PTR-1:0] ldRaw, byteRaw, modRaw;

  assign accHit = accEn && (32'(accSel) < NUM_PTR);

  always_comb begin
    ctl = '0;
    ctl.hit = accHit;
    if (accHit) begin
      case (accMode)
        MODE_POSTINC: begin
          ctl.modify = 1'b1;
        end
        MODE_POSTDEC: begin
          ctl.modify   = 1'b1;
          ctl.stepDown = 1'b1;
        end
        MODE_PREINC: begin
          ctl.modify  = 1'b1;
          ctl.addrInc = 1'b1;
        end
        MODE_OFFSET: begin
          ctl.addrOff = 1'b1;
        end
        default: begin
          // plain and reserved codes: address is the pointer itself
        end
      endcase
    end
  end

  // per-pointer enables, priority load > byte write > auto-modify (R11)
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_hot
    assign ldRaw[i]   = loadEn   && (loadSel == SEL_W'(i));
    assign byteRaw[i] = byteWrEn && (byteSel == SEL_W'(i));
    assign modRaw[i]  = ctl.modify && (accSel == SEL_W'(i));
    assign ldHot[i]   = ldRaw[i];
    assign byteHot[i] = byteRaw[i] && !ldRaw[i];
    assign modHot[i]  = modRaw[i] && !ldRaw[i] && !byteRaw[i];
  end

  assert_ctl_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(modHot));

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_chk
    assert_single_writer_R11: assert property (@(posedge clk) disable iff (!rstN)
      $countones({ldHot[i], byteHot[i], modHot[i]}) <= 1);
  end

  assert_off_no_modify_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accHit && accMode == MODE_OFFSET) |-> (modHot == '0));

endmodule

// File: rtl/ptr_datapath.sv
module ptr_datapath
  import ptr_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int ADDR_W  = 12,
  parameter int BYTE_W  = 8,
  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  localparam int HI_W  = ADDR_W - BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptrCtl_t            ctl,
  input  logic [NUM_PTR-1:0] ldHot,
  input  logic [NUM_PTR-1:0] byteHot,
  input  logic [NUM_PTR-1:0] modHot,
  input  logic [SEL_W-1:0]   accSel,
  input  logic [BYTE_W-1:0]  wreg,
  input  logic [ADDR_W-1:0]  loadVal,
  input  logic               byteHi,
  input  logic [BYTE_W-1:0]  byteData,
  input  logic [SEL_W-1:0]   rdSel,
  input  logic               rdHi,
  output logic [BYTE_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  effAddr
);

  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [ADDR_W-1:0] selPtr;
  logic [ADDR_W-1:0] ptrUp, ptrDown, ptrOff, modVal;
  logic pastValid;

  always_comb begin
    selPtr = '0;
    for (int i = 0; i < NUM_PTR; i++)
      if (accSel == SEL_W'(i)) selPtr = ptrQ[i];
  end

  assign ptrUp   = selPtr + ADDR_W'(1);
  assign ptrDown = selPtr - ADDR_W'(1);
  assign ptrOff  = selPtr + {{HI_W{1'b0}}, wreg};
  assign modVal  = ctl.stepDown ? ptrDown : ptrUp;

  always_comb begin
    if (!ctl.hit)         effAddr = '0;
    else if (ctl.addrInc) effAddr = ptrUp;
    else if (ctl.addrOff) effAddr = ptrOff;
    else                  effAddr = selPtr;
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ptrQ[i] <= '0;
      else if (ldHot[i])
        ptrQ[i] <= loadVal;
      else if (byteHot[i]) begin
        if (byteHi) ptrQ[i][ADDR_W-1:BYTE_W] <= byteData[HI_W-1:0];
        else        ptrQ[i][BYTE_W-1:0]      <= byteData;
      end else if (modHot[i])
        ptrQ[i] <= modVal;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_PTR; i++)
      if (rdSel == SEL_W'(i))
        rdData = rdHi ? {{(BYTE_W-HI_W){1'b0}}, ptrQ[i][ADDR_W-1:BYTE_W]}
                      : ptrQ[i][BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_rd_hi_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdHi |-> (rdData[BYTE_W-1:HI_W] == '0));

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_chk
    assert_step_up_R5: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && modHot[i] && !ctl.stepDown) |=> (ptrQ[i] == $past(ptrQ[i]) + ADDR_W'(1)));
    assert_step_down_R6: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && modHot[i] && ctl.stepDown) |=> (ptrQ[i] == $past(ptrQ[i]) - ADDR_W'(1)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !ldHot[i] && !byteHot[i] && !modHot[i]) |=> $stable(ptrQ[i]));
    assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && ldHot[i]) |=> (ptrQ[i] == $past(loadVal)));
  end

  assert_preinc_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrInc && modHot != '0) |=> (ptrQ[$past(accSel)] == $past(effAddr)));

endmodule

// File: rtl/indirect_ptr_unit.sv
module indirect_ptr_unit
  import ptr_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int ADDR_W  = 12,
  parameter int BYTE_W  = 8,
  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic [SEL_W-1:0]  accSel,
  input  logic [2:0]        accMode,
  input  logic [BYTE_W-1:0] wreg,
  input  logic              loadEn,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              byteWrEn,
  input  logic [SEL_W-1:0]  byteSel,
  input  logic              byteHi,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic              rdHi,
  output logic [BYTE_W-1:0] rdData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              effValid
);

  ptrCtl_t ctl;
  logic [NUM_PTR-1:0] ldHot, byteHot, modHot;

  ptr_ctrl #(.NUM_PTR(NUM_PTR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .accEn(accEn), .accSel(accSel), .accMode(accMode),
    .loadEn(loadEn), .loadSel(loadSel),
    .byteWrEn(byteWrEn), .byteSel(byteSel),
    .ctl(ctl), .ldHot(ldHot), .byteHot(byteHot), .modHot(modHot)
  );

  ptr_datapath #(.NUM_PTR(NUM_PTR), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .ldHot(ldHot), .byteHot(byteHot), .modHot(modHot),
    .accSel(accSel), .wreg(wreg), .loadVal(loadVal),
    .byteHi(byteHi), .byteData(byteData),
    .rdSel(rdSel), .rdHi(rdHi), .rdData(rdData), .effAddr(effAddr)
  );

  assign effValid = ctl.hit;

endmodule

// File: tb/sim_indirect_ptr_unit.sv
module sim_indirect_ptr_unit;
  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic accEn = 0, loadEn = 0, byteWrEn = 0, byteHi = 0, rdHi = 0;
  logic [1:0] accSel = 0, loadSel = 0, byteSel = 0, rdSel = 0;
  logic [2:0] accMode = 0;
  logic [7:0] wreg = 0, byteData = 0, rdData;
  logic [11:0] loadVal = 0, effAddr;
  logic effValid;

  int checks = 0, errors = 0;
  logic [11:0] model [3];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  indirect_ptr_unit u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic checkPtrs(string req);
    for (int i = 0; i < 3; i++) begin
      rdSel = 2'(i); rdHi = 0; #1;
      chk(req, rdData, model[i][7:0]);
      rdHi = 1; #1;
      chk(req, rdData, {4'b0, model[i][11:8]});
    end
    rdHi = 0;
  endtask

  task automatic loadPtr(int sel, logic [11:0] v);
    @(negedge clk);
    loadEn = 1; loadSel = 2'(sel); loadVal = v;
    @(posedge clk); #1;
    loadEn = 0;
    model[sel] = v;
  endtask

  task automatic access(string req, int sel, int mode, logic [7:0] w);
    logic [11:0] p, expA;
    @(negedge clk);
    accEn = 1; accSel = 2'(sel); accMode = 3'(mode); wreg = w;
    #1;
    if (sel < 3) begin
      p = model[sel];
      case (mode)
        3: expA = p + 12'd1;
        4: expA = p + {4'b0, w};
        default: expA = p;
      endcase
      chk(req, effValid, 1);
      chk(req, effAddr, expA);
    end else
      chk(req, effValid, 0);
    @(posedge clk); #1;
    accEn = 0;
    if (sel < 3)
      case (mode)
        1, 3: model[sel] = model[sel] + 12'd1;
        2:    model[sel] = model[sel] - 12'd1;
        default: ;
      endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] vals [8];
    vals = '{12'h000, 12'h001, 12'h0FF, 12'h100, 12'h7FF, 12'hFFE, 12'hFFF, 12'hA5C};
    for (int i = 0; i < 3; i++) model[i] = 0;
    #(CLK_PERIOD * 2 + 3);
    chk("R1", effValid, 0);
    checkPtrs("R1");
    rstN = 1;
    @(negedge clk);
    checkPtrs("R1");

    // R2: literal loads
    for (int i = 0; i < 3; i++) begin
      loadPtr(i, 12'h123 * (i + 1) + 12'h0F0);
      checkPtrs("R2");
    end

    // mode sweep per pointer and value (R4..R10)
    for (int s = 0; s < 3; s++)
      for (int v = 0; v < 8; v++)
        for (int m = 0; m < 8; m++) begin
          loadPtr(s, vals[v]);
          case (m)
            0: access("R4", s, m, 8'h37);
            1: access((vals[v] == 12'hFFF) ? "R9" : "R5", s, m, 8'h37);
            2: access((vals[v] == 12'h000) ? "R9" : "R6", s, m, 8'h37);
            3: access((vals[v] == 12'hFFF) ? "R9" : "R7", s, m, 8'h37);
            4: access("R8", s, m, 8'hC9);
            default: access("R10", s, m, 8'h37);
          endcase
          checkPtrs("R10");
        end

    // R8: full wreg sweep across the 4096 boundary
    loadPtr(1, 12'hF80);
    for (int w = 0; w < 256; w++) access("R8", 1, 4, 8'(w));
    checkPtrs("R8");

    // R9: repeated decrement through zero
    loadPtr(2, 12'h002);
    for (int k = 0; k < 5; k++) access("R9", 2, 2, 0);
    checkPtrs("R9");
    for (int k = 0; k < 5; k++) access("R9", 2, 1, 0);
    checkPtrs("R9");

    // R10: invalid select
    for (int m = 0; m < 8; m++) access("R10", 3, m, 8'h11);
    checkPtrs("R10");

    // R3: byte writes sweep
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 256; b += 17) begin
        @(negedge clk);
        byteWrEn = 1; byteSel = 2'(s); byteHi = 0; byteData = 8'(b);
        @(posedge clk); #1;
        model[s][7:0] = 8'(b);
        byteHi = 1; byteData = 8'(255 - b);
        @(posedge clk); #1;
        byteWrEn = 0; byteHi = 0;
        model[s][11:8] = 4'(255 - b);
        checkPtrs("R3");
      end

    // R11: priority load > byte > modify
    loadPtr(0, 12'h456);
    @(negedge clk);
    loadEn = 1; loadSel = 0; loadVal = 12'h9AB;
    byteWrEn = 1; byteSel = 0; byteHi = 0; byteData = 8'h22;
    accEn = 1; accSel = 0; accMode = 1;
    @(posedge clk); #1;
    loadEn = 0;
    model[0] = 12'h9AB;
    checkPtrs("R11");
    @(posedge clk); #1;   // byte wins over post-increment
    byteWrEn = 0; accEn = 0;
    model[0][7:0] = 8'h22;
    checkPtrs("R11");
    @(negedge clk);
    loadEn = 1; loadSel = 1; loadVal = 12'h3C3;
    accEn = 1; accSel = 1; accMode = 2;
    @(posedge clk); #1;
    loadEn = 0; accEn = 0;
    model[1] = 12'h3C3;
    checkPtrs("R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule